// File: doc/BRIEF.md
# Hysteretic Envelope Pulse Gate

This block is the digital core of a bang-bang power regulator for a switching RF amplifier. Each fast-clock cycle it subtracts a sampled measured envelope from a commanded envelope. A comparator with separate upper and lower trip levels turns that difference into one demand bit. The demand bit says whether the amplifier needs more output power.

The block also builds the carrier that drives the gate stage. The carrier is a square wave made by counting fast-clock cycles. A two-bit symbol picks one of four quarter-period phase offsets, which gives QPSK. A gate register passes carrier pulses to the driver only as whole high half-cycles. It samples the demand bit at each carrier rising edge and drops at each falling edge. The driver therefore sees either a complete 50%-duty pulse or nothing.

The trip levels are loaded through a write strobe. A select bit picks which of the two levels is written.

Top module: `env_gate_top`

## Requirements
- R1: The error is cmdEnv minus measEnv, formed as a W+1-bit signed value so that it never wraps. When the error is strictly greater than the upper trip level, demandOut is 1 after the next clock edge.
- R2: When the error is strictly less than the lower trip level and not greater than the upper one, demandOut is 0 after the next clock edge. If both conditions hold, the upper comparison wins.
- R3: When the error lies within the two trip levels, bounds included, demandOut keeps its previous value.
- R4: A cycle with thrWe=1 writes thrData to the upper trip level when thrSel=0, and to the lower trip level when thrSel=1. The new level is used by comparisons from the following clock edge onward.
- R5: Every high interval of carrierOut lasts exactly HALF fast-clock cycles. While the symbol does not change, every low interval also lasts HALF cycles.
- R6: Let first be the cycle at which carrierOut first rises after reset, and let P=2*HALF. Once a symbol s has been steady long enough, carrierOut rises only at cycles t with (t-first) mod P equal to s*P/4. A new symbol is taken only at the end of a low half-cycle. It is applied by stretching that low interval by ((new-old) mod 4)*P/4 cycles, so no high interval is ever shortened.
- R7: In the cycle where carrierOut goes from 0 to 1, gateOut takes the value that demandOut had in the cycle before. While demandOut stays 0, no gate pulse appears.
- R8: gateOut is 0 whenever carrierOut is 0. A falling carrier edge always ends a gate pulse.
- R9: gateOut does not change while carrierOut stays high. Changes in demand within a carrier cycle neither cut a pulse short nor start one.
- R10: While rst is high at a clock edge, demandOut, gateOut and carrierOut go to 0. Both trip levels go to 0, the applied symbol goes to 0, and the phase counter is placed at the end of a carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdEnv | input | W | Commanded envelope sample, signed |
| measEnv | input | W | Measured envelope sample, signed |
| thrWe | input | 1 | Trip level write strobe |
| thrSel | input | 1 | 0 selects the upper level, 1 selects the lower level |
| thrData | input | W+1 | Trip level value to write, signed |
| symbol | input | 2 | Phase symbol, offset in quarter carrier periods |
| carrierOut | output | 1 | Selected-phase carrier, 50% duty |
| demandOut | output | 1 | Hysteretic demand bit |
| gateOut | output | 1 | Gated carrier to the driver |

## Verification
The bench builds the block with W=10 and HALF=6. This gives a 12-cycle carrier whose quarter-period offset of 3 cycles is long enough to tell every stretched low interval apart from a normal one. With 10-bit samples, a full-scale command minus a full-scale negative measurement reaches the 11-bit error extreme of 1023, and a trip level one below that extreme can still be crossed. Random symbol changes at uneven times exercise every phase difference from 1 to 3 quarters. A long stretch of forced negative error shows that the gate stays silent for many carrier periods.

// File: rtl/env_gate_pkg.sv
package env_gate_pkg;
  // Carrier edge strobes handed from the phase control to the datapath.
  // Each strobe is high for the cycle just before the registered
  // carrier changes.
  typedef struct packed {
    logic rise;
    logic fall;
  } carStrobe_t;
endpackage

// File: rtl/env_gate_ctrl.sv
// Carrier phase sequencer. A period counter makes a square wave of period
// 2*HALF. A symbol change is taken only at the end of a low half-cycle and
// is applied by lengthening that low interval by a whole number of quarter
// periods. HALF must be even so that a quarter period is an integer.
module env_gate_ctrl
  import env_gate_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] symbol,
  output carStrobe_t strb,
  output logic       carrier
);
  localparam int PER  = 2 * HALF;
  localparam int QTR  = PER / 4;
  localparam int CW   = $clog2(PER);
  localparam int HW   = $clog2(3 * QTR + 1);

  logic [CW-1:0] phCnt, phNext;
  logic [HW-1:0] holdCnt, holdNext;
  logic          holding, holdingNext;
  logic [1:0]    curSym, symNext;
  logic          carQ, carNext;
  logic [1:0]    symDelta;

  assign symDelta = symbol - curSym;

  always_comb begin
    phNext      = phCnt;
    holdNext    = holdCnt;
    holdingNext = holding;
    symNext     = curSym;
    if (holding) begin
      holdNext = holdCnt - HW'(1);
      if (holdCnt == HW'(1)) begin
        holdingNext = 1'b0;
        phNext      = '0;
      end
    end else if (phCnt == CW'(PER - 1)) begin
      if (symbol != curSym) begin
        holdingNext = 1'b1;
        holdNext    = HW'(int'(symDelta) * QTR);
        symNext     = symbol;
      end else begin
        phNext = '0;
      end
    end else begin
      phNext = phCnt + CW'(1);
    end
    carNext = !holdingNext && (phNext < CW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phCnt   <= CW'(PER - 1);
      holdCnt <= '0;
      holding <= 1'b0;
      curSym  <= 2'd0;
      carQ    <= 1'b0;
    end else begin
      phCnt   <= phNext;
      holdCnt <= holdNext;
      holding <= holdingNext;
      curSym  <= symNext;
      carQ    <= carNext;
    end
  end

  assign strb.rise = carNext & ~carQ;
  assign strb.fall = ~carNext & carQ;
  assign carrier   = carQ;
endmodule

// File: rtl/env_gate_dpath.sv
// Error subtraction, hysteretic comparator with two trip registers, and
// the gate register that passes whole carrier high half-cycles.
module env_gate_dpath
  import env_gate_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] cmdEnv,
  input  logic signed [W-1:0] measEnv,
  input  logic                thrWe,
  input  logic                thrSel,
  input  logic signed [W:0]   thrData,
  input  carStrobe_t          strb,
  output logic                demand,
  output logic                gate
);
  localparam int EW = W + 1;

  logic signed [EW-1:0] errVal;
  logic signed [EW-1:0] thrHi, thrLo;
  logic                 aboveHi, belowLo;

  // Sign-extend by one bit so the difference cannot wrap.
  assign errVal  = $signed({cmdEnv[W-1], cmdEnv}) - $signed({measEnv[W-1], measEnv});
  assign aboveHi = errVal > thrHi;
  assign belowLo = errVal < thrLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      thrHi <= '0;
      thrLo <= '0;
    end else if (thrWe) begin
      if (thrSel) thrLo <= thrData;
      else        thrHi <= thrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          demand <= 1'b0;
    else if (aboveHi) demand <= 1'b1;
    else if (belowLo) demand <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            gate <= 1'b0;
    else if (strb.rise) gate <= demand;
    else if (strb.fall) gate <= 1'b0;
  end
endmodule

// File: rtl/env_gate_top.sv
module env_gate_top
  import env_gate_pkg::*;
#(
  parameter int W    = 8,
  parameter int HALF = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] cmdEnv,
  input  logic signed [W-1:0] measEnv,
  input  logic                thrWe,
  input  logic                thrSel,
  input  logic signed [W:0]   thrData,
  input  logic [1:0]          symbol,
  output logic                carrierOut,
  output logic                demandOut,
  output logic                gateOut
);
  carStrobe_t strb;

  env_gate_ctrl #(.HALF(HALF)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .symbol  (symbol),
    .strb    (strb),
    .carrier (carrierOut)
  );

  env_gate_dpath #(.W(W)) uDpath (
    .clk     (clk),
    .rst     (rst),
    .cmdEnv  (cmdEnv),
    .measEnv (measEnv),
    .thrWe   (thrWe),
    .thrSel  (thrSel),
    .thrData (thrData),
    .strb    (strb),
    .demand  (demandOut),
    .gate    (gateOut)
  );
endmodule

// File: rtl/env_gate_chk.sv
module env_gate_chk #(
  parameter int HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic carrierOut,
  input logic demandOut,
  input logic gateOut
);
  int unsigned highLen;

  always_ff @(posedge clk) begin
    if (rst)             highLen <= 0;
    else if (carrierOut) highLen <= highLen + 1;
    else                 highLen <= 0;
  end

  a_r5_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(carrierOut) |-> (highLen == HALF));

  a_r7_capture_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(carrierOut) |-> (gateOut == $past(demandOut)));

  a_r7_gate_starts_with_carrier: assert property (@(posedge clk) disable iff (rst)
    $rose(gateOut) |-> $rose(carrierOut));

  a_r8_gate_inside_carrier: assert property (@(posedge clk) disable iff (rst)
    gateOut |-> carrierOut);

  a_r9_gate_steady: assert property (@(posedge clk) disable iff (rst)
    (carrierOut && $past(carrierOut)) |-> $stable(gateOut));
endmodule

bind env_gate_top env_gate_chk #(.HALF(HALF)) uChk (
  .clk        (clk),
  .rst        (rst),
  .carrierOut (carrierOut),
  .demandOut  (demandOut),
  .gateOut    (gateOut)
);

// File: tb/tb_env_gate_top.sv
`timescale 1ns/1ps
module tb_env_gate_top;
  localparam int W    = 10;
  localparam int HALF = 6;
  localparam int PER  = 2 * HALF;
  localparam int QTR  = PER / 4;
  localparam int NCYC = 6000;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic signed [W-1:0] cmdEnv = '0;
  logic signed [W-1:0] measEnv = '0;
  logic                thrWe = 1'b0;
  logic                thrSel = 1'b0;
  logic signed [W:0]   thrData = '0;
  logic [1:0]          symbol = 2'd0;
  logic                carrierOut, demandOut, gateOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  env_gate_top #(.W(W), .HALF(HALF)) dut (
    .clk(clk), .rst(rst), .cmdEnv(cmdEnv), .measEnv(measEnv),
    .thrWe(thrWe), .thrSel(thrSel), .thrData(thrData), .symbol(symbol),
    .carrierOut(carrierOut), .demandOut(demandOut), .gateOut(gateOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expDemand(input int err, input int hi, input int lo, input int prev);
    if (err > hi) return 1;
    if (err < lo) return 0;
    return prev;
  endfunction

  // Stimulus state applied at the previous falling edge
  int appErr = 0;
  int appWe = 0, appSel = 0, appData = 0;
  int hiM = 0, loM = 0, demM = 0;
  int wroteLast = 0;

  task automatic drive(input int c, input int m, input int we, input int sel, input int d);
    cmdEnv  = W'(c);
    measEnv = W'(m);
    thrWe   = we[0];
    thrSel  = sel[0];
    thrData = (W+1)'(d);
    appErr  = c - m;
    appWe   = we; appSel = sel; appData = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc = 0;
    int prevCar = 0, prevDem = 0, prevGate = 0;
    int firstRise = -1;
    int lowRun = 0, highRun = 0;
    int lastSymChg = -100000;
    int curSymM = 0;
    void'($urandom(32'd20240611));

    // R10: reset state
    repeat (3) @(negedge clk);
    check(carrierOut == 1'b0, "R10 carrier in reset", int'(carrierOut), 0);
    check(demandOut == 1'b0, "R10 demand in reset", int'(demandOut), 0);
    check(gateOut == 1'b0, "R10 gate in reset", int'(gateOut), 0);
    rst = 1'b0;

    for (int i = 0; i < NCYC; i++) begin
      int car, dem, gte, expD;
      string rq;
      @(negedge clk);
      cyc++;
      car = int'(carrierOut); dem = int'(demandOut); gte = int'(gateOut);

      // Comparator model: inputs applied last cycle, levels before the edge
      expD = expDemand(appErr, hiM, loM, demM);
      if (wroteLast != 0)      rq = "R4 level write then compare";
      else if (appErr > hiM)   rq = "R1 error above upper";
      else if (appErr < loM)   rq = "R2 error below lower";
      else                     rq = "R3 error inside band";
      check(dem == expD, rq, dem, expD);
      demM = expD;
      wroteLast = appWe;
      if (appWe != 0) begin
        if (appSel != 0) loM = appData;
        else             hiM = appData;
      end

      // Carrier and gate
      if (car == 1 && prevCar == 0) begin
        check(gte == prevDem, "R7 gate captures demand at rise", gte, prevDem);
        if (firstRise < 0) begin
          firstRise = cyc;
        end else begin
          if (cyc - lastSymChg >= 3 * PER) begin
            check(lowRun == HALF, "R5 low width steady symbol", lowRun, HALF);
            check(((cyc - firstRise) % PER) == curSymM * QTR, "R6 phase offset",
                  (cyc - firstRise) % PER, curSymM * QTR);
          end else begin
            check(lowRun >= HALF && lowRun <= HALF + 3 * QTR && ((lowRun - HALF) % QTR) == 0,
                  "R6 stretched low interval", lowRun, HALF);
          end
        end
        lowRun = 0;
      end
      if (car == 0 && prevCar == 1) begin
        check(highRun == HALF, "R5 high width", highRun, HALF);
        highRun = 0;
      end
      if (car != 0) highRun++;
      else          lowRun++;
      if (car == 0) check(gte == 0, "R8 gate low with carrier low", gte, 0);
      if (car == 1 && prevCar == 1)
        check(gte == prevGate, "R9 gate steady within pulse", gte, prevGate);
      prevCar = car; prevDem = dem; prevGate = gte;

      // Symbol stimulus
      if (cyc > 30 && ($urandom % 150) == 0) begin
        int ns;
        ns = int'($urandom % 4);
        if (ns != curSymM) lastSymChg = cyc;
        curSymM = ns;
        symbol = 2'(ns);
      end

      // Data stimulus
      if (cyc <= 14) begin
        case (cyc)
          1:  drive(0, 0, 1, 0, 5);
          2:  drive(0, 0, 1, 1, -5);
          3:  drive(6, 0, 0, 0, 0);
          4:  drive(5, 0, 0, 0, 0);
          5:  drive(0, 5, 0, 0, 0);
          6:  drive(0, 6, 0, 0, 0);
          7:  drive(5, 0, 0, 0, 0);
          8:  drive(0, 0, 1, 0, 1022);
          9:  drive(511, -512, 0, 0, 0);   // R1: 1023, the widest error
          10: drive(0, 0, 1, 0, -10);
          11: drive(-20, 0, 1, 1, 10);
          12: drive(0, 0, 0, 0, 0);        // R2: both true, upper wins
          13: drive(20, 0, 0, 0, 0);
          default: drive(0, 0, 1, 0, 0);
        endcase
      end else if (cyc >= 1500 && cyc < 2500) begin
        // R7: demand held low, no pulses may pass
        drive(-100, 100, 0, 0, 0);
      end else begin
        int c, m, we, sel, d;
        if (($urandom % 8) == 0) begin
          c = int'($urandom % 1024) - 512;
          m = int'($urandom % 1024) - 512;
        end else begin
          c = int'($urandom % 801) - 400;
          m = c - (int'($urandom % 121) - 60);
        end
        we  = (($urandom % 16) == 0) ? 1 : 0;
        sel = int'($urandom % 2);
        d   = int'($urandom % 81) - 40;
        drive(c, m, we, sel, d);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule